// File: doc/BRIEF.md
# Serial Flash Page-Safe Write Sequencer

This block turns a byte-stream write request into a series of serial-flash program operations. A request gives a start address and a length. The data bytes then arrive one at a time on a valid/ready byte port. The sequencer cuts the stream into chunks of at most four bytes. A chunk never runs past the end of a 256-byte flash page, because the flash would otherwise wrap the excess bytes back to the start of the same page.

For each chunk it drives a command engine, one command at a time, in this order:
1. A lone write-enable command.
2. A page-program command that carries the 24-bit address and the packed data.
3. Repeated status reads, until the write-in-progress bit is clear.

The serial shifting is done by the command engine. The engine must raise its busy flag in the cycle after it accepts a start, and hold it until the command has finished.

A request that would run past the end of the device is rejected at once, and no command is sent. A zero-length request completes at once. If the status poll never clears, a poll limit ends the request with a timeout failure.

The state machine has ten states:
- IDLE: waits for a request.
- CHECK: tests for zero length and range, and plans the first chunk.
- LOAD: takes the chunk bytes from the byte port.
- WREN: issues the write enable. WREN_WAIT waits for it to finish.
- PROG: issues the page program. PROG_WAIT waits for it to finish.
- POLL: issues a status read. POLL_WAIT waits for it and examines the result.
- ADVANCE: moves the address, remaining length and byte count on by the chunk length.

Its transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | request accepted | CHECK |
| CHECK | zero length (done) or out of range (fail) | IDLE |
| CHECK | otherwise | LOAD |
| LOAD | chunk full | WREN |
| WREN, PROG, POLL | engine not busy (a start is issued) | the matching WAIT state |
| WREN_WAIT | engine not busy | PROG |
| PROG_WAIT | engine not busy | POLL |
| POLL_WAIT | status bit 0 clear | ADVANCE |
| POLL_WAIT | bit 0 set and poll limit reached (fail) | IDLE |
| POLL_WAIT | bit 0 set otherwise | POLL |
| ADVANCE | nothing remains (done) | IDLE |
| ADVANCE | otherwise | LOAD |

Top module: `flash_prog_seq`

## Requirements
- R1: Each chunk length is the smallest of MAX_CHUNK (4), the bytes still remaining, and the bytes left to the end of the current PAGE_BYTES (256) page. No program command covers bytes of two pages.
- R2: Every page program is preceded by a write-enable command (opcode 0x06, transmit count 1, receive count 0) issued on its own. A start pulse is issued only while the engine is not busy.
- R3: A page program uses opcode 0x02, the 24-bit chunk address, receive count 0, and transmit count equal to the chunk length plus 4.
- R4: Chunk data is packed little-endian: the first byte in bits 7:0, the next in bits 15:8, and so on. Lanes beyond the chunk length are zero.
- R5: After each program, status reads (opcode 0x05, transmit 1, receive 1) repeat until bit 0 of the returned data is 0. Only then does the next chunk start.
- R6: If the address plus length is greater than DEV_BYTES, the request ends with a one-cycle fail pulse and fail_code 2'b01, and no command is issued.
- R7: A zero-length request ends with a done pulse and issues no command. This check takes priority over the range check.
- R8: Bits 31:24 of the request address are ignored. Commands use only bits 23:0.
- R9: After each chunk completes, the address, the remaining length and bytes_done all advance by the chunk length. At done, bytes_done equals the request length.
- R10: If MAX_POLLS consecutive status reads for one chunk all return bit 0 set, the request ends with a fail pulse and fail_code 2'b10, and no further command is issued.
- R11: seq_done is a one-cycle pulse and is never high together with seq_fail. A request that arrives while seq_busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 32 | Start byte address; only bits 23:0 are used |
| req_len | input | LEN_W | Number of bytes to write |
| dat_valid | input | 1 | Data byte available |
| dat_byte | input | 8 | Data byte |
| dat_ready | output | 1 | Sequencer takes the byte this cycle |
| ce_start | output | 1 | One-cycle command start to the engine |
| ce_opcode | output | 8 | Command opcode |
| ce_addr | output | 24 | Command address |
| ce_wdata | output | 32 | Command write data, packed little-endian |
| ce_tx_cnt | output | 4 | Bytes to transmit (opcode included) |
| ce_rx_cnt | output | 4 | Bytes to receive |
| ce_busy | input | 1 | Engine busy; high from the cycle after a start until the command ends |
| ce_rdata | input | 32 | Engine receive data; bit 0 is write-in-progress on a status read |
| seq_busy | output | 1 | A request is in progress |
| seq_done | output | 1 | One-cycle success pulse |
| seq_fail | output | 1 | One-cycle failure pulse |
| fail_code | output | 2 | 00 none, 01 range, 10 poll timeout; held until the next request |
| bytes_done | output | LEN_W | Bytes programmed for the current request |

## Verification
A wrong chunk length or address register shows at once on the next page-program command. It shows as a transmit count that crosses a page edge, or as data that lands at a wrapped flash address; the flash model's memory exposes this within the same request. A stuck or skipped state shows as a missing write enable before a program, as a status poll count that differs from the one computed for that chunk, or as a done or fail pulse that is missing or carries the wrong code. Every one of these is visible at the engine port or the completion pulse within a few tens of cycles of the fault.

// File: rtl/fps_pkg.sv
package fps_pkg;
    localparam int ADDR_W  = 24;
    localparam int HDR_LEN = 4;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_RDSR = 8'h05;

    localparam logic [1:0] FC_NONE    = 2'b00;
    localparam logic [1:0] FC_RANGE   = 2'b01;
    localparam logic [1:0] FC_TIMEOUT = 2'b10;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_LOAD,
        S_WREN,
        S_WREN_WAIT,
        S_PROG,
        S_PROG_WAIT,
        S_POLL,
        S_POLL_WAIT,
        S_ADVANCE
    } seq_state_e;
endpackage

// File: rtl/fps_chunk_plan.sv
module fps_chunk_plan
    import fps_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int MAX_CHUNK  = 4,
    parameter int LEN_W      = 25,
    parameter int DEV_BYTES  = 16777216,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int CLEN_W    = $clog2(MAX_CHUNK + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    output logic [CLEN_W-1:0] clen,
    output logic              past_end
);
    logic [31:0] offs;
    logic [31:0] room;
    logic [31:0] lim;
    logic [32:0] last;

    always_comb begin
        offs = 32'(addr[PAGE_W-1:0]);
        room = 32'(PAGE_BYTES) - offs;
        lim  = 32'(MAX_CHUNK);
        if (32'(rem) < lim) lim = 32'(rem);
        if (room < lim)     lim = room;
        clen     = CLEN_W'(lim);
        last     = 33'(addr) + 33'(rem);
        past_end = last > 33'(DEV_BYTES);
    end
endmodule

// File: rtl/fps_byte_pack.sv
module fps_byte_pack #(
    parameter int MAX_CHUNK = 4,
    localparam int CLEN_W   = $clog2(MAX_CHUNK + 1),
    localparam int WORD_W   = 8 * MAX_CHUNK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word,
    output logic [CLEN_W-1:0] count
);
    logic [CLEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (take)   cnt_q <= cnt_q + 1'b1;
    end

    for (genvar g = 0; g < MAX_CHUNK; g++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              lane_q <= '0;
            else if (clear)                          lane_q <= '0;
            else if (take && cnt_q == CLEN_W'(g))    lane_q <= byte_in;
        end
        assign word[8*g +: 8] = lane_q;
    end

    assign count = cnt_q;

    // R4: a byte is only taken while a free lane exists
    assert_lane_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (32'(cnt_q) < MAX_CHUNK));
endmodule

// File: rtl/fps_poll_timer.sv
module fps_poll_timer #(
    parameter int MAX_POLLS = 100000,
    localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clear)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CNT_W'(MAX_POLLS - 1));

    // R10: the retry count never passes the poll limit
    assert_poll_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < MAX_POLLS);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import fps_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int MAX_CHUNK  = 4,
    parameter int LEN_W      = 25,
    parameter int DEV_BYTES  = 16777216,
    parameter int MAX_POLLS  = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             dat_valid,
    input  logic [7:0]       dat_byte,
    output logic             dat_ready,
    output logic             ce_start,
    output logic [7:0]       ce_opcode,
    output logic [23:0]      ce_addr,
    output logic [31:0]      ce_wdata,
    output logic [3:0]       ce_tx_cnt,
    output logic [3:0]       ce_rx_cnt,
    input  logic             ce_busy,
    input  logic [31:0]      ce_rdata,
    output logic             seq_busy,
    output logic             seq_done,
    output logic             seq_fail,
    output logic [1:0]       fail_code,
    output logic [LEN_W-1:0] bytes_done
);
    localparam int CLEN_W = $clog2(MAX_CHUNK + 1);
    localparam int WORD_W = 8 * MAX_CHUNK;
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    seq_state_e state, nstate;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [CLEN_W-1:0] clen_q;
    logic [LEN_W-1:0]  bytes_q;
    logic              done_q, fail_q;
    logic [1:0]        code_q;

    logic [ADDR_W-1:0] nxt_addr;
    logic [LEN_W-1:0]  nxt_rem;
    logic [ADDR_W-1:0] plan_addr;
    logic [LEN_W-1:0]  plan_rem;
    logic [CLEN_W-1:0] plan_clen;
    logic              plan_over;

    logic              pk_clear, pk_take;
    logic [WORD_W-1:0] pk_word;
    logic [CLEN_W-1:0] pk_cnt;

    logic              wip, poll_last, poll_clear, poll_retry, poll_giveup;
    logic              unused_bits;

    assign unused_bits = ^{req_addr[31:24], ce_rdata[31:1]};

    assign nxt_addr  = addr_q + ADDR_W'(clen_q);
    assign nxt_rem   = rem_q - LEN_W'(clen_q);
    assign plan_addr = (state == S_ADVANCE) ? nxt_addr : addr_q;
    assign plan_rem  = (state == S_ADVANCE) ? nxt_rem  : rem_q;

    fps_chunk_plan #(
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_CHUNK  (MAX_CHUNK),
        .LEN_W      (LEN_W),
        .DEV_BYTES  (DEV_BYTES)
    ) u_plan (
        .addr     (plan_addr),
        .rem      (plan_rem),
        .clen     (plan_clen),
        .past_end (plan_over)
    );

    assign pk_clear  = (state == S_CHECK) || (state == S_ADVANCE);
    assign pk_take   = dat_valid && dat_ready;

    fps_byte_pack #(.MAX_CHUNK(MAX_CHUNK)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (pk_clear),
        .take    (pk_take),
        .byte_in (dat_byte),
        .word    (pk_word),
        .count   (pk_cnt)
    );

    assign wip         = ce_rdata[0];
    assign poll_clear  = (state == S_PROG_WAIT);
    assign poll_retry  = (state == S_POLL_WAIT) && !ce_busy && wip && !poll_last;
    assign poll_giveup = (state == S_POLL_WAIT) && !ce_busy && wip && poll_last;

    fps_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .tick  (poll_retry),
        .last  (poll_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:      if (req_valid) nstate = S_CHECK;
            S_CHECK: begin
                if (rem_q == '0)    nstate = S_IDLE;
                else if (plan_over) nstate = S_IDLE;
                else                nstate = S_LOAD;
            end
            S_LOAD:      if (pk_cnt == clen_q) nstate = S_WREN;
            S_WREN:      if (!ce_busy) nstate = S_WREN_WAIT;
            S_WREN_WAIT: if (!ce_busy) nstate = S_PROG;
            S_PROG:      if (!ce_busy) nstate = S_PROG_WAIT;
            S_PROG_WAIT: if (!ce_busy) nstate = S_POLL;
            S_POLL:      if (!ce_busy) nstate = S_POLL_WAIT;
            S_POLL_WAIT: begin
                if (!ce_busy) begin
                    if (!wip)           nstate = S_ADVANCE;
                    else if (poll_last) nstate = S_IDLE;
                    else                nstate = S_POLL;
                end
            end
            S_ADVANCE:   nstate = (nxt_rem == '0) ? S_IDLE : S_LOAD;
            default:     nstate = S_IDLE;
        endcase
    end

    // request datapath and completion pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rem_q   <= '0;
            clen_q  <= '0;
            bytes_q <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            code_q  <= FC_NONE;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr[ADDR_W-1:0];
                        rem_q   <= req_len;
                        bytes_q <= '0;
                        code_q  <= FC_NONE;
                    end
                end
                S_CHECK: begin
                    clen_q <= plan_clen;
                    if (rem_q == '0) begin
                        done_q <= 1'b1;
                    end else if (plan_over) begin
                        fail_q <= 1'b1;
                        code_q <= FC_RANGE;
                    end
                end
                S_POLL_WAIT: begin
                    if (poll_giveup) begin
                        fail_q <= 1'b1;
                        code_q <= FC_TIMEOUT;
                    end
                end
                S_ADVANCE: begin
                    addr_q  <= nxt_addr;
                    rem_q   <= nxt_rem;
                    bytes_q <= bytes_q + LEN_W'(clen_q);
                    clen_q  <= plan_clen;
                    if (nxt_rem == '0) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dat_ready = 1'b0;
        ce_start  = 1'b0;
        ce_opcode = 8'h00;
        ce_addr   = addr_q;
        ce_wdata  = '0;
        ce_tx_cnt = 4'd0;
        ce_rx_cnt = 4'd0;
        unique case (state)
            S_LOAD: dat_ready = (pk_cnt < clen_q);
            S_WREN, S_WREN_WAIT: begin
                ce_start  = (state == S_WREN) && !ce_busy;
                ce_opcode = OP_WREN;
                ce_tx_cnt = 4'd1;
            end
            S_PROG, S_PROG_WAIT: begin
                ce_start  = (state == S_PROG) && !ce_busy;
                ce_opcode = OP_PROG;
                ce_wdata  = 32'(pk_word);
                ce_tx_cnt = 4'(clen_q) + 4'(HDR_LEN);
            end
            S_POLL, S_POLL_WAIT: begin
                ce_start  = (state == S_POLL) && !ce_busy;
                ce_opcode = OP_RDSR;
                ce_tx_cnt = 4'd1;
                ce_rx_cnt = 4'd1;
            end
            default: ;
        endcase
    end

    assign seq_busy   = (state != S_IDLE);
    assign seq_done   = done_q;
    assign seq_fail   = fail_q;
    assign fail_code  = code_q;
    assign bytes_done = bytes_q;

    // ---------------- assertions ----------------
    logic wel_armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_armed <= 1'b0;
        else if (ce_start && ce_opcode == OP_WREN) wel_armed <= 1'b1;
        else if (ce_start && ce_opcode == OP_PROG) wel_armed <= 1'b0;
    end

    // R1: a program never crosses a page edge
    assert_page_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_start && ce_opcode == OP_PROG) |->
        (32'(ce_addr[PAGE_W-1:0]) + 32'(ce_tx_cnt) - HDR_LEN <= PAGE_BYTES));

    // R2: every program follows its own write enable
    assert_wren_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_start && ce_opcode == OP_PROG) |-> wel_armed);

    // R3: program length lies in 1..MAX_CHUNK data bytes
    assert_prog_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_start && ce_opcode == OP_PROG) |->
        (ce_tx_cnt > 4'(HDR_LEN)) && (32'(ce_tx_cnt) <= HDR_LEN + MAX_CHUNK) && (ce_rx_cnt == 4'd0));

    // R5: a chunk advances only after a clear status
    assert_wip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADVANCE) |-> !$past(ce_rdata[0]));

    // R6: a range rejection has programmed nothing
    assert_range_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fail && fail_code == FC_RANGE) |-> (bytes_done == '0));

    // R11: done is a single-cycle pulse and excludes fail
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
    assert_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_fail));
endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
    localparam int DEV   = 1024;
    localparam int POLLS = 8;
    localparam int LW    = 12;
    localparam int PAGE  = 256;
    localparam int MAXC  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          dat_valid;
    logic [7:0]    dat_byte;
    logic          dat_ready;
    logic          ce_start;
    logic [7:0]    ce_opcode;
    logic [23:0]   ce_addr;
    logic [31:0]   ce_wdata;
    logic [3:0]    ce_tx_cnt, ce_rx_cnt;
    logic          ce_busy;
    logic [31:0]   ce_rdata;
    logic          seq_busy, seq_done, seq_fail;
    logic [1:0]    fail_code;
    logic [LW-1:0] bytes_done;

    flash_prog_seq #(
        .PAGE_BYTES(PAGE), .MAX_CHUNK(MAXC), .LEN_W(LW),
        .DEV_BYTES(DEV), .MAX_POLLS(POLLS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .dat_ready(dat_ready), .ce_start(ce_start), .ce_opcode(ce_opcode),
        .ce_addr(ce_addr), .ce_wdata(ce_wdata), .ce_tx_cnt(ce_tx_cnt),
        .ce_rx_cnt(ce_rx_cnt), .ce_busy(ce_busy), .ce_rdata(ce_rdata),
        .seq_busy(seq_busy), .seq_done(seq_done), .seq_fail(seq_fail),
        .fail_code(fail_code), .bytes_done(bytes_done)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'(seed * 31 + i * 7 + 1);
    endfunction

    // ---------------- command engine and flash model ----------------
    logic [7:0]  mem [0:DEV-1];
    int          bcnt;
    logic [31:0] rdata_q;
    int          n_wren, n_prog, n_poll, n_cmd;
    int          wip_left;
    bit          wel;
    bit          wip_forever = 1'b0;
    int          base_prog = 0;
    int          m_n;
    logic [23:0] m_a;

    assign ce_busy  = (bcnt != 0);
    assign ce_rdata = rdata_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= 0;
            rdata_q <= '0;
            wel = 1'b0;
            wip_left = 0;
            n_wren = 0; n_prog = 0; n_poll = 0; n_cmd = 0;
            for (int i = 0; i < DEV; i++) mem[i] = 8'h00;
        end else begin
            if (bcnt > 0) bcnt <= bcnt - 1;
            if (ce_start) begin
                chk(bcnt == 0, "R2 start while engine busy", bcnt, 0);
                n_cmd++;
                bcnt <= 3;
                case (ce_opcode)
                    8'h06: begin
                        chk(ce_tx_cnt == 4'd1 && ce_rx_cnt == 4'd0, "R2 write-enable counts",
                            {ce_tx_cnt, ce_rx_cnt}, 8'h10);
                        wel = 1'b1;
                        n_wren++;
                    end
                    8'h02: begin
                        m_n = int'(ce_tx_cnt) - 4;
                        chk(wel, "R2 program without write enable", wel, 1);
                        chk(m_n >= 1 && m_n <= MAXC && ce_rx_cnt == 4'd0, "R3 program counts", m_n, 4);
                        chk(int'(ce_addr[7:0]) + m_n <= PAGE, "R1 program crosses page",
                            int'(ce_addr[7:0]) + m_n, PAGE);
                        chk(int'(ce_addr) < DEV, "R8 program address outside device", ce_addr, DEV);
                        chk(m_n >= 4 || (ce_wdata >> (8 * m_n)) == 0, "R4 unused lanes nonzero",
                            ce_wdata, 0);
                        for (int i = 0; i < m_n && i < 4; i++) begin
                            m_a = {ce_addr[23:8], ce_addr[7:0] + 8'(i)};
                            if (int'(m_a) < DEV) mem[m_a[9:0]] = ce_wdata[8*i +: 8];
                        end
                        wel = 1'b0;
                        wip_left = (n_prog - base_prog) % 3;
                        n_prog++;
                    end
                    8'h05: begin
                        chk(ce_tx_cnt == 4'd1 && ce_rx_cnt == 4'd1, "R5 status read counts",
                            {ce_tx_cnt, ce_rx_cnt}, 8'h11);
                        rdata_q <= {31'b0, wip_forever || (wip_left != 0)};
                        if (wip_left > 0) wip_left--;
                        n_poll++;
                    end
                    default: chk(1'b0, "R2 unexpected opcode", ce_opcode, 0);
                endcase
            end
        end
    end

    // ---------------- byte source ----------------
    int taken = 0;
    int base_taken = 0;
    int cur_seed = 0;
    bit stall = 1'b0;
    int tick = 0;

    always @(posedge clk) begin
        tick <= tick + 1;
        if (dat_valid && dat_ready) taken <= taken + 1;
    end

    assign dat_valid = stall ? ((tick % 3) != 0) : 1'b1;
    assign dat_byte  = pat(cur_seed, taken - base_taken);

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", wd, 190000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- request driver ----------------
    task automatic run_req(input logic [31:0] a32, input int len, input int seed,
                           input bit intr, input bit expect_to);
        int  eff;
        int  c0, w0, p0, q0;
        int  a, r, k, c, ech, epol, cyc, bad;
        bit  got_d, got_f;
        logic [1:0] code;
        eff = int'(a32[23:0]);
        @(negedge clk);
        cur_seed   = seed;
        base_taken = taken;
        base_prog  = n_prog;
        stall      = seed[0];
        c0 = n_cmd; w0 = n_wren; p0 = n_prog; q0 = n_poll;
        req_addr  = a32;
        req_len   = LW'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got_d = 1'b0; got_f = 1'b0; code = 2'b00; cyc = 0;
        while (!got_d && !got_f && cyc < 20000) begin
            if (seq_done) got_d = 1'b1;
            if (seq_fail) begin got_f = 1'b1; code = fail_code; end
            if (!(got_d || got_f)) begin
                if (intr && cyc == 6) begin
                    req_addr = 32'd600; req_len = LW'(4); req_valid = 1'b1;
                end else begin
                    req_valid = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        req_valid = 1'b0;
        chk(got_d || got_f, "R9 request never completed", cyc, 20000);
        @(negedge clk);
        chk(!seq_done, "R11 done wider than one cycle", seq_done, 0);
        repeat (6) @(negedge clk);

        if (len == 0) begin
            chk(got_d && !got_f, "R7 zero-length outcome", {got_d, got_f}, 2);
            chk(n_cmd == c0, "R7 command on zero-length", n_cmd - c0, 0);
        end else if (eff + len > DEV) begin
            chk(got_f && !got_d && code == 2'b01, "R6 range rejection code", code, 1);
            chk(n_cmd == c0, "R6 command on rejected request", n_cmd - c0, 0);
        end else if (expect_to) begin
            chk(got_f && code == 2'b10, "R10 timeout code", code, 2);
            chk(n_prog - p0 == 1, "R10 programs before timeout", n_prog - p0, 1);
            chk(n_poll - q0 == POLLS, "R10 polls before timeout", n_poll - q0, POLLS);
            c0 = n_cmd;
            repeat (20) @(negedge clk);
            chk(n_cmd == c0 && !seq_busy, "R10 command after timeout", n_cmd - c0, 0);
        end else begin
            a = eff; r = len; k = 0; epol = 0;
            while (r > 0) begin
                c = MAXC;
                if (r < c) c = r;
                if (PAGE - (a % PAGE) < c) c = PAGE - (a % PAGE);
                epol += (k % 3) + 1;
                a += c; r -= c; k++;
            end
            ech = k;
            chk(got_d && !got_f, "R9 completion outcome", {got_d, got_f}, 2);
            chk(n_prog - p0 == ech, "R1 program count", n_prog - p0, ech);
            chk(n_wren - w0 == ech, "R2 write-enable count", n_wren - w0, ech);
            chk(n_poll - q0 == epol, "R5 status poll count", n_poll - q0, epol);
            chk(int'(bytes_done) == len, "R9 bytes_done", bytes_done, len);
            bad = -1;
            for (int i = 0; i < len; i++)
                if (bad < 0 && mem[eff + i] != pat(seed, i)) bad = i;
            chk(bad < 0, (a32[31:24] != 0) ? "R8 data at masked address" : "R4 programmed data",
                bad, -1);
            if (intr) begin
                bad = 0;
                for (int i = 0; i < 4; i++) if (mem[600 + i] != 8'h00) bad++;
                chk(bad == 0, "R11 request while busy was not ignored", bad, 0);
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!seq_busy && !seq_done && !seq_fail, "R11 reset status", {seq_busy, seq_done, seq_fail}, 0);
        chk(!ce_start && !dat_ready && bytes_done == '0 && fail_code == 2'b00,
            "R9 reset outputs", bytes_done, 0);

        // sweep start offsets around page and device edges with short lengths
        foreach (bases_q[bi]) begin
            for (int off = 0; off < 12; off++) begin
                for (int len = 0; len <= 10; len++) begin
                    run_req(32'(bases_q[bi] + off), len, bi * 977 + off * 16 + len, 1'b0, 1'b0);
                end
            end
        end

        // long request spanning two page edges
        run_req(32'd100, 300, 77, 1'b0, 1'b0);
        // request arriving while busy is ignored
        run_req(32'd40, 9, 12, 1'b1, 1'b0);
        // upper address bits ignored
        run_req(32'hAB00_0104, 5, 333, 1'b0, 1'b0);
        // last byte of device is allowed
        run_req(32'd1020, 4, 91, 1'b0, 1'b0);
        // status never clears
        wip_forever = 1'b1;
        run_req(32'd300, 6, 55, 1'b0, 1'b1);
        wip_forever = 1'b0;
        // recovery after timeout
        run_req(32'd700, 7, 21, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    int bases_q [4] = '{0, 252, 508, 1012};
endmodule